// File: doc/BRIEF.md
# Power-Fail Guarded Byte Memory Bus Front-End

This block terminates an SRAM-style bus (active-low chip select, output enable and write strobe, an 11-bit byte address and an 8-bit data path) and steers it into a 2 KiB internal store. The top eight byte addresses are not plain memory. They go to a small timekeeper register bank, whose contents are brought out in parallel for the clock logic next to this block. The rest of the space is general-purpose RAM. The bus is sampled on the block clock. Read data and its output enable are registered and appear one cycle after the bus asks for them. A write lands in the cycle where the strobe pair stops being jointly active.

Two digital flags from the supply monitor shape access. While `pwr_fail` is high the block behaves as deselected: nothing is driven and nothing is stored. When power is declared good again, either at reset or on the falling edge of `pwr_fail`, a high `batt_low` arms a sticky lockout. The next write that would have been committed is dropped instead, and that dropped attempt releases the lockout. Software detects this by writing a complement and reading it back.

Top module: `pf_sram_front`

## Requirements
- R1: A write is active in a cycle where `cs_n` and `wr_n` are both low and `pwr_fail` is low. It is committed in the first following cycle where that is no longer true, using the address and data of the last active cycle. Read-back of the location then returns the new byte.
- R2: When a cycle has `cs_n`=0, `wr_n`=1, `rd_n`=0 and `pwr_fail`=0, the next cycle has `dq_oe`=1 and `dq_out` equal to the byte stored at that cycle's address. Otherwise the next cycle has `dq_oe`=0.
- R3: A cycle with `wr_n`=0 turns `dq_oe` off in the following cycle, even while `cs_n` and `rd_n` stay low.
- R4: Addresses 7F8h..7FFh reach the timekeeper bank, with address 7F8h+k shown on `tk_regs[8k+7:8k]`. All lower addresses reach RAM. A write on one side never changes the other side.
- R5: While `pwr_fail` is high, no output is driven and no write is committed. This holds for writes that start or end during the flag.
- R6: `batt_low` sampled high at reset, or in the cycle `pwr_fail` falls, sets a lockout. The first write that would commit afterwards is discarded and clears the lockout. Later writes store normally. With `batt_low` low, no write is discarded.
- R7: A write that is still active when `pwr_fail` rises is abandoned, and every other location keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| pwr_fail | input | 1 | Supply out of tolerance; forces deselect |
| batt_low | input | 1 | Backup cell low; arms the first-write lockout |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Read data drive enable |
| tk_regs | output | 64 | Parallel view of the eight timekeeper bytes |

## Verification
The embedded properties watch every cycle to confirm that output drive follows a qualified read one cycle later. They also confirm that a low write strobe or a raised power-fail flag always leaves the data path undriven, that no store commit ever occurs while power-fail is high, and that every commit is preceded by a jointly active strobe. The contents of memory can only be judged by the bench's reference model. This covers which byte a commit stores, the one write swallowed by the lockout, the survival of neighbouring locations when a write is abandoned, and the separation between RAM and timekeeper bytes. The bench shows these through complement write-back sequences and read-back.

// File: rtl/pf_sram_pkg.sv
package pf_sram_pkg;
    localparam int unsigned ADDR_W_DEF = 11;
    localparam int unsigned DATA_W_DEF = 8;
    localparam int unsigned TK_NUM_DEF = 8;

    typedef enum logic {
        TGT_RAM = 1'b0,
        TGT_TK  = 1'b1
    } target_e;
endpackage

// File: rtl/pf_bus_ctrl.sv
module pf_bus_ctrl #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              pwr_fail,
    input  logic              batt_low,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              drive_q
);
    typedef struct packed {
        logic              wr_act;
        logic [ADDR_W-1:0] w_addr;
        logic [DATA_W-1:0] w_data;
        logic              lockout;
        logic              pf_seen;
        logic              drive;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  act_now;

    always_comb begin
        st_d      = st_q;
        commit_en = 1'b0;
        act_now   = !pwr_fail && !cs_n && !wr_n;

        // strobe pair just released: commit or swallow
        if (st_q.wr_act && !pwr_fail && !act_now) begin
            if (st_q.lockout) begin
                st_d.lockout = 1'b0;
            end else begin
                commit_en = 1'b1;
            end
        end

        if (act_now) begin
            st_d.w_addr = addr;
            st_d.w_data = din;
        end
        st_d.wr_act = act_now;

        // power declared good again
        st_d.pf_seen = pwr_fail;
        if (st_q.pf_seen && !pwr_fail && batt_low) begin
            st_d.lockout = 1'b1;
        end

        st_d.drive = !pwr_fail && !cs_n && wr_n && !rd_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.lockout <= batt_low;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_addr = st_q.w_addr;
    assign commit_data = st_q.w_data;
    assign drive_q     = st_q.drive;

    // R5: nothing is committed while power is failing
    a_r5_no_commit_in_pfail: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> !commit_en);

    // R1: a commit is always preceded by a jointly active strobe pair
    a_r1_commit_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> $past(!cs_n && !wr_n));
endmodule

// File: rtl/pf_byte_store.sv
module pf_byte_store #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2040
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem_q[waddr] <= wdata;
        end
        if (int'(raddr) < DEPTH) begin
            rdata_q <= mem_q[raddr];
        end else begin
            rdata_q <= '0;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pf_tk_bank.sv
module pf_tk_bank #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TK_NUM = 8,
    localparam int unsigned IDX_W = $clog2(TK_NUM)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         widx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [IDX_W-1:0]         ridx,
    output logic [DATA_W-1:0]        rdata,
    output logic [TK_NUM*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] reg_q [TK_NUM];
    logic [DATA_W-1:0] reg_d [TK_NUM];
    logic [DATA_W-1:0] rdata_q, rdata_d;

    always_comb begin
        for (int i = 0; i < TK_NUM; i++) begin
            reg_d[i] = reg_q[i];
        end
        if (we) begin
            reg_d[widx] = wdata;
        end
        rdata_d = reg_q[ridx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TK_NUM; i++) begin
                reg_q[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            for (int i = 0; i < TK_NUM; i++) begin
                reg_q[i] <= reg_d[i];
            end
            rdata_q <= rdata_d;
        end
    end

    for (genvar g = 0; g < TK_NUM; g++) begin : g_flat
        assign regs_flat[g*DATA_W +: DATA_W] = reg_q[g];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pf_sram_front.sv
module pf_sram_front
    import pf_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned TK_NUM = TK_NUM_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        din,
    input  logic                     pwr_fail,
    input  logic                     batt_low,
    output logic [DATA_W-1:0]        dq_out,
    output logic                     dq_oe,
    output logic [TK_NUM*DATA_W-1:0] tk_regs
);
    localparam int unsigned SPACE   = 1 << ADDR_W;
    localparam int unsigned RAM_NUM = SPACE - TK_NUM;
    localparam int unsigned IDX_W   = $clog2(TK_NUM);
    localparam logic [ADDR_W-1:0] TK_BASE = ADDR_W'(RAM_NUM);

    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic              drive_q;
    logic              ram_we, tk_we;
    logic [DATA_W-1:0] ram_rdata, tk_rdata;
    target_e           tgt_q, tgt_d;

    pf_bus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .din        (din),
        .pwr_fail   (pwr_fail),
        .batt_low   (batt_low),
        .commit_en  (commit_en),
        .commit_addr(commit_addr),
        .commit_data(commit_data),
        .drive_q    (drive_q)
    );

    always_comb begin
        ram_we = commit_en && (commit_addr <  TK_BASE);
        tk_we  = commit_en && (commit_addr >= TK_BASE);
        tgt_d  = (addr >= TK_BASE) ? TGT_TK : TGT_RAM;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= TGT_RAM;
        end else begin
            tgt_q <= tgt_d;
        end
    end

    pf_byte_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(RAM_NUM)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(commit_addr),
        .wdata(commit_data),
        .raddr(addr),
        .rdata(ram_rdata)
    );

    pf_tk_bank #(.DATA_W(DATA_W), .TK_NUM(TK_NUM)) u_tk (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tk_we),
        .widx     (commit_addr[IDX_W-1:0]),
        .wdata    (commit_data),
        .ridx     (addr[IDX_W-1:0]),
        .rdata    (tk_rdata),
        .regs_flat(tk_regs)
    );

    assign dq_oe  = drive_q;
    assign dq_out = (tgt_q == TGT_TK) ? tk_rdata : ram_rdata;

    // R2: a qualified read drives the bus one cycle later
    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_n && !rd_n && !pwr_fail) |=> dq_oe);

    // R3: a low write strobe releases the bus next cycle
    a_r3_strobe_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> !dq_oe);

    // R5: power-fail leaves the bus undriven
    a_r5_pfail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !dq_oe);
endmodule

// File: tb/tb_pf_sram_front.sv
module tb_pf_sram_front;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int TKN = 8;
    localparam int SPACE = 1 << AW;
    localparam int TKB = SPACE - TKN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic pwr_fail = 1'b0, batt_low = 1'b0;
    logic [DW-1:0] dq_out;
    logic dq_oe;
    logic [TKN*DW-1:0] tk_regs;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pf_sram_front dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .pwr_fail(pwr_fail), .batt_low(batt_low),
        .dq_out(dq_out), .dq_oe(dq_oe), .tk_regs(tk_regs)
    );

    // behavioural reference model
    logic [DW-1:0] m [SPACE];
    logic          m_pend = 1'b0;
    logic [AW-1:0] m_waddr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic          m_lock = 1'b0;
    logic          m_pfp = 1'b0;
    logic          exp_oe = 1'b0;
    logic [DW-1:0] exp_out = '0;

    initial begin
        for (int i = 0; i < SPACE; i++) m[i] = 'x;
    end

    always @(posedge clk) begin
        bit active;
        if (!rst_n) begin
            m_pend = 1'b0;
            m_lock = batt_low;
            m_pfp  = 1'b0;
            exp_oe = 1'b0;
            for (int k = 0; k < TKN; k++) m[TKB + k] = '0;
        end else begin
            active  = !pwr_fail && !cs_n && !wr_n;
            exp_oe  = !pwr_fail && !cs_n && wr_n && !rd_n;
            exp_out = m[addr];
            if (m_pend && !pwr_fail && !active) begin
                if (m_lock) m_lock = 1'b0;
                else m[m_waddr] = m_wdata;
            end
            if (active) begin
                m_waddr = addr;
                m_wdata = din;
            end
            m_pend = active;
            if (m_pfp && !pwr_fail && batt_low) m_lock = 1'b1;
            m_pfp = pwr_fail;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 drive", {7'd0, dq_oe}, {7'd0, exp_oe});
            if (exp_oe && !$isunknown(exp_out)) chk("R1 data", dq_out, exp_out);
            for (int k = 0; k < TKN; k++)
                chk("R4 tk view", tk_regs[k*DW +: DW], m[TKB + k]);
        end
    end

    task automatic idle();
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = a;
        @(negedge clk);
        d = dq_out;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic power_cycle(input logic low);
        idle();
        pwr_fail = 1'b1;
        repeat (3) @(negedge clk);
        batt_low = low;
        pwr_fail = 1'b0;
        @(negedge clk);
        batt_low = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v, v2;
        repeat (3) @(negedge clk);
        chk("R2 reset", {7'd0, dq_oe}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: basic writes and read-back, several patterns
        wr(11'h005, 8'h3C); rd(11'h005, v); chk("R1", v, 8'h3C);
        wr(11'h400, 8'hFF); rd(11'h400, v); chk("R1", v, 8'hFF);
        wr(11'h7F7, 8'h81); rd(11'h7F7, v); chk("R1", v, 8'h81);
        // long strobe, data changes; last active cycle wins
        cs_n = 1'b0; wr_n = 1'b0; addr = 11'h006; din = 8'h11;
        @(negedge clk); din = 8'h22;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        rd(11'h006, v); chk("R1 last data", v, 8'h22);

        // R2: no drive when rd_n high or cs_n high
        cs_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; addr = 11'h005;
        @(negedge clk); chk("R2 rd_n high", {7'd0, dq_oe}, 8'd0);
        cs_n = 1'b1; rd_n = 1'b0;
        @(negedge clk); chk("R2 cs_n high", {7'd0, dq_oe}, 8'd0);
        idle();

        // R3: strobe low while reading releases the bus
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = 11'h005;
        @(negedge clk); chk("R3 before", {7'd0, dq_oe}, 8'd1);
        wr_n = 1'b0; din = 8'h77;
        @(negedge clk); chk("R3 released", {7'd0, dq_oe}, 8'd0);
        wr_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        rd(11'h005, v); chk("R3 write landed", v, 8'h77);

        // R4: timekeeper region
        for (int k = 0; k < TKN; k++) wr(11'(TKB + k), 8'(8'hA0 + k));
        for (int k = 0; k < TKN; k++) chk("R4 slice", tk_regs[k*DW +: DW], 8'(8'hA0 + k));
        rd(11'h7FB, v); chk("R4 read tk", v, 8'hA3);
        rd(11'h7F7, v); chk("R4 ram untouched", v, 8'h81);

        // R5: power-fail blocks writes and reads
        wr(11'h010, 8'h10);
        pwr_fail = 1'b1;
        @(negedge clk);
        wr(11'h010, 8'hEE);
        cs_n = 1'b0; rd_n = 1'b0; addr = 11'h010;
        @(negedge clk); chk("R5 no drive", {7'd0, dq_oe}, 8'd0);
        idle();
        pwr_fail = 1'b0;
        @(negedge clk);
        rd(11'h010, v); chk("R5 no write", v, 8'h10);

        // R7: write abandoned by power-fail, neighbours intact
        wr(11'h01F, 8'h1F); wr(11'h021, 8'h21);
        cs_n = 1'b0; wr_n = 1'b0; addr = 11'h020; din = 8'h99;
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk); pwr_fail = 1'b0;
        @(negedge clk);
        rd(11'h01F, v); chk("R7 lower", v, 8'h1F);
        rd(11'h021, v); chk("R7 upper", v, 8'h21);

        // R6: battery check with battery low
        wr(11'h123, 8'h5A);
        power_cycle(1'b1);
        rd(11'h123, v);
        wr(11'h123, ~v);
        rd(11'h123, v2); chk("R6 low: write swallowed", v2, v);
        wr(11'h123, ~v);
        rd(11'h123, v2); chk("R6 later write stores", v2, ~v);
        wr(11'h123, v);

        // R6: battery check with battery good
        power_cycle(1'b0);
        rd(11'h123, v);
        wr(11'h123, ~v);
        rd(11'h123, v2); chk("R6 good: complement stored", v2, ~v);
        wr(11'h123, v);

        // R6: lockout armed at reset
        idle();
        batt_low = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; batt_low = 1'b0;
        @(negedge clk);
        wr(11'h7F8, 8'h42);
        chk("R6 reset lockout", tk_regs[DW-1:0], 8'h00);
        wr(11'h7F8, 8'h43);
        chk("R6 after lockout", tk_regs[DW-1:0], 8'h43);

        idle(); idle();
        finish_run();
    end
endmodule